// File: doc/BRIEF.md
# Processor Subsystem Power-Down Sequencer

This block takes a processor subsystem from running to fully off, in a fixed order that keeps the shutdown safe. A single stop request starts the sequence. The block first asks an external halt controller to quiesce the subsystem's bus interface, and it waits for that handshake to finish before it gates the core clock. It then applies the I/O clamp and the word-line clamp, drops the L2 data standby-not and sleep-retention-not controls, and removes power from the memory banks. Banks go off one at a time in ascending order, with a guaranteed millisecond-scale gap between steps so that current changes stay small.

After the last bank is off, the block clamps the memories and turns off the power headswitch. It waits a short settle time measured in microsecond ticks, then polls the headswitch acknowledge input on each millisecond tick. Once the acknowledge clears, the block asserts the subsystem reset and then the processor reset, and it reports done. If the acknowledge is still set after the poll limit, the block halts in an error state. In that state every clamp stays applied and neither reset is asserted. The halt controller, the switches and the memories sit outside the block. They are reached only through the ports.

Top module: `ss_teardown_seq`

## Requirements
- R1: The block stays idle until `stop_req` is high at a clock edge. It then raises `halt_start` and holds it until `halt_done` is seen. `core_clk_en` stays 1 until then and drops to 0 at the same edge that lowers `halt_start`.
- R2: After the clock is gated, the following events occur on four consecutive edges, one per edge: `io_clamp` rises, then `wl_clamp` rises, then `l2_stby_n` falls, then `slp_ret_n` falls.
- R3: In `bank_pwr`, bit i powers bank i (1 = on). Banks are switched off one bit per step, in order from bank 0 to bank NBANK-1, starting after `slp_ret_n` has fallen. At the end all bits are 0.
- R4: Between two consecutive bank steps, and between the last bank step and the memory clamp, the block counts at least BANK_GAP_MS+1 `ms_tick` pulses.
- R5: `mem_clamp` rises only after every bank is off. `hs_en` falls after `mem_clamp` is set. Polling starts only after at least HS_SETTLE_US+1 `us_tick` pulses.
- R6: The block samples `hs_ack` on each `ms_tick` while it polls. The first sample found at 0 leads to `subsys_rst` rising, and `proc_rst` rises one cycle later. `seq_done` goes high together with `proc_rst` and stays high.
- R7: If POLL_MAX samples all find `hs_ack` at 1, `seq_err` goes high and stays high. In that case `io_clamp`, `wl_clamp` and `mem_clamp` stay 1, while `subsys_rst`, `proc_rst` and `seq_done` stay 0.
- R8: During reset the outputs take these values: `core_clk_en`, `l2_stby_n`, `slp_ret_n` and `hs_en` are 1, and `bank_pwr` is all ones. Every clamp, both resets, `halt_start`, `seq_done` and `seq_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Starts the power-down sequence |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| halt_start | output | 1 | Bus halt request to the halt controller |
| halt_done | input | 1 | Bus halt completed |
| core_clk_en | output | 1 | Core clock enable |
| io_clamp | output | 1 | I/O clamp |
| wl_clamp | output | 1 | Word-line clamp |
| l2_stby_n | output | 1 | L2 data standby-not control |
| slp_ret_n | output | 1 | Sleep-retention-not control |
| bank_pwr | output | NBANK | Per-bank memory power, 1 = on |
| mem_clamp | output | 1 | Memory clamp |
| hs_en | output | 1 | Power headswitch enable |
| hs_ack | input | 1 | Headswitch status acknowledge |
| subsys_rst | output | 1 | Subsystem reset |
| proc_rst | output | 1 | Processor reset |
| seq_done | output | 1 | Sequence finished |
| seq_err | output | 1 | Headswitch acknowledge timeout |

## Verification
The bench builds the block with NBANK=4 and POLL_MAX=6, and keeps the one-tick gap and settle defaults. With only four banks, every bank step and every gap can be checked tick by tick within a short run. The small poll limit makes the timeout path reachable in a few dozen millisecond ticks. Tick spacing, halt latency and acknowledge delay are drawn at random, so the waits land at different points relative to the ticks.

// File: rtl/tdn_pkg.sv
package tdn_pkg;
  typedef enum logic [4:0] {
    ST_IDLE, ST_HALT, ST_IOC, ST_WLC, ST_STBY, ST_RET,
    ST_BANK, ST_BGAP, ST_MCLAMP, ST_HSOFF, ST_SETTLE,
    ST_POLL, ST_SSRST, ST_PRST, ST_DONE, ST_ERR
  } tdn_state_e;
endpackage

// File: rtl/tdn_timer.sv
module tdn_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          tick,
  input  logic [CW-1:0] target,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          last;

  assign last = (cnt_q == target - CW'(1));
  assign done = armed_q && tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (arm) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (armed_q && tick) begin
      if (last) armed_q <= 1'b0;
      else      cnt_q   <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/tdn_bank_vec.sv
module tdn_bank_vec #(
  parameter int NBANK = 20,
  parameter int IW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off_stb,
  input  logic [IW-1:0]    idx,
  output logic [NBANK-1:0] pwr
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = off_stb && (idx == IW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pwr[b] <= 1'b1;
      else if (hit) pwr[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/tdn_fsm.sv
module tdn_fsm
  import tdn_pkg::*;
#(
  parameter int NBANK    = 20,
  parameter int POLL_MAX = 200,
  parameter int IW       = 5,
  parameter int PW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_req,
  input  logic          halt_done,
  input  logic          hs_ack,
  input  logic          ms_tick,
  input  logic          tmr_done,
  output logic          tmr_arm,
  output logic          tmr_use_us,
  output logic          bank_off,
  output logic [IW-1:0] bank_idx,
  output logic          halt_start,
  output logic          core_clk_en,
  output logic          io_clamp,
  output logic          wl_clamp,
  output logic          l2_stby_n,
  output logic          slp_ret_n,
  output logic          mem_clamp,
  output logic          hs_en,
  output logic          subsys_rst,
  output logic          proc_rst,
  output logic          seq_done,
  output logic          seq_err
);
  tdn_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [PW-1:0] poll_q, poll_d;
  logic halt_q, halt_d, clk_q, clk_d, io_q, io_d, wl_q, wl_d;
  logic stby_q, stby_d, ret_q, ret_d, mcl_q, mcl_d, hs_q, hs_d;
  logic ss_q, ss_d, pr_q, pr_d;

  always_comb begin
    st_d = st_q;     idx_d = idx_q;   poll_d = poll_q;
    halt_d = halt_q; clk_d = clk_q;   io_d = io_q;     wl_d = wl_q;
    stby_d = stby_q; ret_d = ret_q;   mcl_d = mcl_q;   hs_d = hs_q;
    ss_d = ss_q;     pr_d = pr_q;
    tmr_arm = 1'b0;  tmr_use_us = 1'b0; bank_off = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (stop_req) begin halt_d = 1'b1; st_d = ST_HALT; end
      ST_HALT:   if (halt_done) begin
                   halt_d = 1'b0; clk_d = 1'b0; st_d = ST_IOC;
                 end
      ST_IOC:    begin io_d = 1'b1;   st_d = ST_WLC;  end
      ST_WLC:    begin wl_d = 1'b1;   st_d = ST_STBY; end
      ST_STBY:   begin stby_d = 1'b0; st_d = ST_RET;  end
      ST_RET:    begin ret_d = 1'b0; idx_d = '0; st_d = ST_BANK; end
      ST_BANK:   begin bank_off = 1'b1; tmr_arm = 1'b1; st_d = ST_BGAP; end
      ST_BGAP:   if (tmr_done) begin
                   if (idx_q == IW'(NBANK - 1)) st_d = ST_MCLAMP;
                   else begin idx_d = idx_q + IW'(1); st_d = ST_BANK; end
                 end
      ST_MCLAMP: begin mcl_d = 1'b1; st_d = ST_HSOFF; end
      ST_HSOFF:  begin hs_d = 1'b0; tmr_arm = 1'b1; st_d = ST_SETTLE; end
      ST_SETTLE: begin
                   tmr_use_us = 1'b1;
                   if (tmr_done) begin poll_d = '0; st_d = ST_POLL; end
                 end
      ST_POLL:   if (ms_tick) begin
                   if (!hs_ack)                          st_d = ST_SSRST;
                   else if (poll_q == PW'(POLL_MAX - 1)) st_d = ST_ERR;
                   else                                  poll_d = poll_q + PW'(1);
                 end
      ST_SSRST:  begin ss_d = 1'b1; st_d = ST_PRST; end
      ST_PRST:   begin pr_d = 1'b1; st_d = ST_DONE; end
      default:   st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0;   poll_q <= '0;
      halt_q <= 1'b0;  clk_q <= 1'b1; io_q <= 1'b0;  wl_q <= 1'b0;
      stby_q <= 1'b1;  ret_q <= 1'b1; mcl_q <= 1'b0; hs_q <= 1'b1;
      ss_q <= 1'b0;    pr_q <= 1'b0;
    end else begin
      st_q <= st_d;    idx_q <= idx_d; poll_q <= poll_d;
      halt_q <= halt_d; clk_q <= clk_d; io_q <= io_d; wl_q <= wl_d;
      stby_q <= stby_d; ret_q <= ret_d; mcl_q <= mcl_d; hs_q <= hs_d;
      ss_q <= ss_d;     pr_q <= pr_d;
    end
  end

  assign bank_idx    = idx_q;
  assign halt_start  = halt_q;
  assign core_clk_en = clk_q;
  assign io_clamp    = io_q;
  assign wl_clamp    = wl_q;
  assign l2_stby_n   = stby_q;
  assign slp_ret_n   = ret_q;
  assign mem_clamp   = mcl_q;
  assign hs_en       = hs_q;
  assign subsys_rst  = ss_q;
  assign proc_rst    = pr_q;
  assign seq_done    = (st_q == ST_DONE);
  assign seq_err     = (st_q == ST_ERR);
endmodule

// File: rtl/ss_teardown_seq.sv
module ss_teardown_seq #(
  parameter int NBANK        = 20,
  parameter int POLL_MAX     = 200,
  parameter int BANK_GAP_MS  = 1,
  parameter int HS_SETTLE_US = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             ms_tick,
  input  logic             us_tick,
  output logic             halt_start,
  input  logic             halt_done,
  output logic             core_clk_en,
  output logic             io_clamp,
  output logic             wl_clamp,
  output logic             l2_stby_n,
  output logic             slp_ret_n,
  output logic [NBANK-1:0] bank_pwr,
  output logic             mem_clamp,
  output logic             hs_en,
  input  logic             hs_ack,
  output logic             subsys_rst,
  output logic             proc_rst,
  output logic             seq_done,
  output logic             seq_err
);
  localparam int IW      = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int PW      = $clog2(POLL_MAX) + 1;
  localparam int BANK_TG = BANK_GAP_MS + 1;
  localparam int HS_TG   = HS_SETTLE_US + 1;
  localparam int TG_MAX  = (BANK_TG > HS_TG) ? BANK_TG : HS_TG;
  localparam int CW      = $clog2(TG_MAX + 1);

  logic          tmr_arm, tmr_use_us, tmr_done, tmr_tick, bank_off;
  logic [IW-1:0] bank_idx;
  logic [CW-1:0] tmr_target;

  assign tmr_tick   = tmr_use_us ? us_tick : ms_tick;
  assign tmr_target = tmr_use_us ? CW'(HS_TG) : CW'(BANK_TG);

  tdn_fsm #(.NBANK(NBANK), .POLL_MAX(POLL_MAX), .IW(IW), .PW(PW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .halt_done(halt_done),
    .hs_ack(hs_ack), .ms_tick(ms_tick), .tmr_done(tmr_done),
    .tmr_arm(tmr_arm), .tmr_use_us(tmr_use_us), .bank_off(bank_off),
    .bank_idx(bank_idx), .halt_start(halt_start), .core_clk_en(core_clk_en),
    .io_clamp(io_clamp), .wl_clamp(wl_clamp), .l2_stby_n(l2_stby_n),
    .slp_ret_n(slp_ret_n), .mem_clamp(mem_clamp), .hs_en(hs_en),
    .subsys_rst(subsys_rst), .proc_rst(proc_rst),
    .seq_done(seq_done), .seq_err(seq_err)
  );

  tdn_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(tmr_arm), .tick(tmr_tick),
    .target(tmr_target), .done(tmr_done)
  );

  tdn_bank_vec #(.NBANK(NBANK), .IW(IW)) u_banks (
    .clk(clk), .rst_n(rst_n), .off_stb(bank_off), .idx(bank_idx),
    .pwr(bank_pwr)
  );
endmodule

// File: rtl/ss_teardown_seq_chk.sv
module ss_teardown_seq_chk #(
  parameter int NBANK = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_done,
  input logic             core_clk_en,
  input logic             io_clamp,
  input logic             wl_clamp,
  input logic             l2_stby_n,
  input logic             slp_ret_n,
  input logic [NBANK-1:0] bank_pwr,
  input logic             mem_clamp,
  input logic             hs_en,
  input logic             subsys_rst,
  input logic             proc_rst,
  input logic             seq_done,
  input logic             seq_err
);
  AST_CLK_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> $past(halt_done)); // R1
  AST_WL_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_clamp) |-> io_clamp && !core_clk_en); // R2
  AST_RET_AFTER_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp_ret_n) |-> !l2_stby_n && wl_clamp); // R2
  AST_ONE_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_pwr) |-> ($countones($past(bank_pwr) ^ bank_pwr) == 1)
                           && ((bank_pwr & ~$past(bank_pwr)) == '0)); // R3
  AST_BANKS_AFTER_RET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_pwr) |-> !slp_ret_n); // R3
  AST_MCLAMP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_clamp) |-> (bank_pwr == '0)); // R5
  AST_HS_AFTER_MCLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> mem_clamp); // R5
  AST_SS_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(subsys_rst) |-> !hs_en && !proc_rst); // R6
  AST_PROC_AFTER_SS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proc_rst) |-> subsys_rst && $past(subsys_rst)); // R6
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> io_clamp && wl_clamp && mem_clamp && !subsys_rst && !proc_rst
                && !seq_done); // R7
endmodule

bind ss_teardown_seq ss_teardown_seq_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_done(halt_done), .core_clk_en(core_clk_en),
  .io_clamp(io_clamp), .wl_clamp(wl_clamp), .l2_stby_n(l2_stby_n),
  .slp_ret_n(slp_ret_n), .bank_pwr(bank_pwr), .mem_clamp(mem_clamp),
  .hs_en(hs_en), .subsys_rst(subsys_rst), .proc_rst(proc_rst),
  .seq_done(seq_done), .seq_err(seq_err)
);

// File: tb/test_ss_teardown_seq.sv
`timescale 1ns/1ps
module test_ss_teardown_seq;
  localparam int NB  = 4;
  localparam int PM  = 6;
  localparam int GAP = 1;
  localparam int SET = 1;
  localparam int E_HD = 0, E_CLK = 1, E_IO = 2, E_WL = 3, E_STBY = 4, E_RET = 5;
  localparam int E_MCL = 6, E_HS = 7, E_SS = 8, E_PR = 9, E_DONE = 10, E_ERR = 11;
  localparam int E_B0 = 12, NE = 12 + NB;

  logic clk = 1'b0, rst_n = 1'b0, stop_req = 1'b0, ms_tick = 1'b0, us_tick = 1'b0;
  logic halt_done = 1'b0, hs_ack = 1'b1;
  logic halt_start, core_clk_en, io_clamp, wl_clamp, l2_stby_n, slp_ret_n;
  logic mem_clamp, hs_en, subsys_rst, proc_rst, seq_done, seq_err;
  logic [NB-1:0] bank_pwr;

  int vectors = 0, fails = 0;
  bit finished = 0;
  int ack_delay = 0, ack_wait = 0;
  bit ack_stuck = 0;
  int ms_ctr = 0, us_ctr = 0;
  int ev_t[NE], ev_ms[NE], ev_us[NE];
  int cyc = 0, ms_cum = 0, us_cum = 0;
  logic ack_at_ss;
  int seed_dummy;

  always #2.5 clk = ~clk;

  ss_teardown_seq #(.NBANK(NB), .POLL_MAX(PM), .BANK_GAP_MS(GAP), .HS_SETTLE_US(SET))
  i_ss_teardown_seq (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .ms_tick(ms_tick),
    .us_tick(us_tick), .halt_start(halt_start), .halt_done(halt_done),
    .core_clk_en(core_clk_en), .io_clamp(io_clamp), .wl_clamp(wl_clamp),
    .l2_stby_n(l2_stby_n), .slp_ret_n(slp_ret_n), .bank_pwr(bank_pwr),
    .mem_clamp(mem_clamp), .hs_en(hs_en), .hs_ack(hs_ack),
    .subsys_rst(subsys_rst), .proc_rst(proc_rst),
    .seq_done(seq_done), .seq_err(seq_err)
  );

  function automatic int exp_bank_ticks();
    return GAP + 1;
  endfunction
  function automatic int exp_settle_ticks();
    return SET + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      ms_tick = (ms_ctr == 0);
      ms_ctr  = (ms_ctr == 0) ? int'($urandom_range(5, 2)) : ms_ctr - 1;
      us_tick = (us_ctr == 0);
      us_ctr  = (us_ctr == 0) ? int'($urandom_range(1, 0)) : us_ctr - 1;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      if (!rst_n) begin
        hs_ack = 1'b1; ack_wait = ack_delay;
      end else if (!ack_stuck && !hs_en && ms_tick) begin
        if (ack_wait == 0) hs_ack = 1'b0;
        else ack_wait--;
      end
    end
  end

  always @(negedge clk) begin
    logic [NE-1:0] cond;
    cond[E_HD] = halt_done;   cond[E_CLK] = !core_clk_en;
    cond[E_IO] = io_clamp;    cond[E_WL] = wl_clamp;
    cond[E_STBY] = !l2_stby_n; cond[E_RET] = !slp_ret_n;
    cond[E_MCL] = mem_clamp;  cond[E_HS] = !hs_en;
    cond[E_SS] = subsys_rst;  cond[E_PR] = proc_rst;
    cond[E_DONE] = seq_done;  cond[E_ERR] = seq_err;
    for (int b = 0; b < NB; b++) cond[E_B0 + b] = !bank_pwr[b];
    cyc++;
    for (int e = 0; e < NE; e++) begin
      if (!rst_n) ev_t[e] = -1;
      else if (ev_t[e] < 0 && cond[e]) begin
        ev_t[e] = cyc; ev_ms[e] = ms_cum; ev_us[e] = us_cum;
        if (e == E_SS) ack_at_ss = hs_ack;
      end
    end
    ms_cum += int'(ms_tick);
    us_cum += int'(us_tick);
  end

  task automatic run_one(input int delay_i, input bit stuck);
    int d, lim;
    ack_delay = delay_i; ack_stuck = stuck;
    @(negedge clk); rst_n = 1'b0; stop_req = 1'b0; halt_done = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset values
    chk(core_clk_en && l2_stby_n && slp_ret_n && hs_en && bank_pwr == '1,
        "R8 on-state outputs", {bank_pwr, core_clk_en, hs_en}, {{NB{1'b1}}, 2'b11});
    chk(!io_clamp && !wl_clamp && !mem_clamp && !subsys_rst && !proc_rst &&
        !halt_start && !seq_done && !seq_err, "R8 off-state outputs",
        int'(io_clamp | wl_clamp | mem_clamp | subsys_rst | proc_rst | halt_start), 0);
    rst_n = 1'b1;
    repeat ($urandom_range(4, 1)) @(negedge clk);
    // R1: idle without stop_req
    chk(!halt_start && core_clk_en, "R1 idle before stop", int'(halt_start), 0);
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    d = $urandom_range(6, 2);
    repeat (d) @(negedge clk);
    chk(halt_start && core_clk_en && !io_clamp, "R1 clock held during halt",
        {halt_start, core_clk_en, io_clamp}, 3'b110);
    halt_done = 1'b1;
    lim = 0;
    while (halt_start && lim < 100) begin @(negedge clk); lim++; end
    halt_done = 1'b0;
    lim = 0;
    while (!seq_done && !seq_err && lim < 20000) begin @(negedge clk); lim++; end
    repeat (5) @(negedge clk);

    chk(ev_t[E_CLK] > ev_t[E_HD] && ev_t[E_HD] > 0, "R1 clock gated after halt",
        ev_t[E_CLK], ev_t[E_HD] + 1);
    chk(ev_t[E_IO] == ev_t[E_CLK] + 1, "R2 io clamp", ev_t[E_IO], ev_t[E_CLK] + 1);
    chk(ev_t[E_WL] == ev_t[E_IO] + 1, "R2 wl clamp", ev_t[E_WL], ev_t[E_IO] + 1);
    chk(ev_t[E_STBY] == ev_t[E_WL] + 1, "R2 standby", ev_t[E_STBY], ev_t[E_WL] + 1);
    chk(ev_t[E_RET] == ev_t[E_STBY] + 1, "R2 retention", ev_t[E_RET], ev_t[E_STBY] + 1);
    chk(ev_t[E_B0] > ev_t[E_RET], "R3 first bank after retention", ev_t[E_B0], ev_t[E_RET] + 1);
    for (int b = 1; b < NB; b++) begin
      chk(ev_t[E_B0 + b] > ev_t[E_B0 + b - 1], "R3 ascending bank order",
          ev_t[E_B0 + b], ev_t[E_B0 + b - 1] + 1);
      chk(ev_ms[E_B0 + b] - ev_ms[E_B0 + b - 1] >= exp_bank_ticks(), "R4 bank gap ticks",
          ev_ms[E_B0 + b] - ev_ms[E_B0 + b - 1], exp_bank_ticks());
    end
    chk(bank_pwr == '0, "R3 all banks off", int'(bank_pwr), 0);
    chk(ev_ms[E_MCL] - ev_ms[E_B0 + NB - 1] >= exp_bank_ticks(), "R4 gap before mem clamp",
        ev_ms[E_MCL] - ev_ms[E_B0 + NB - 1], exp_bank_ticks());
    chk(ev_t[E_MCL] > ev_t[E_B0 + NB - 1] && ev_t[E_HS] > ev_t[E_MCL],
        "R5 clamp then headswitch off", ev_t[E_HS], ev_t[E_MCL] + 1);

    if (!stuck) begin
      chk(seq_done && !seq_err, "R6 done reported", {seq_done, seq_err}, 2'b10);
      chk(ev_us[E_SS] - ev_us[E_HS] >= exp_settle_ticks(), "R5 settle ticks",
          ev_us[E_SS] - ev_us[E_HS], exp_settle_ticks());
      chk(ev_ms[E_SS] - ev_ms[E_HS] >= delay_i + 1, "R6 waits for ack clear",
          ev_ms[E_SS] - ev_ms[E_HS], delay_i + 1);
      chk(ack_at_ss == 1'b0, "R6 ack clear at reset", int'(ack_at_ss), 0);
      chk(ev_t[E_PR] == ev_t[E_SS] + 1, "R6 processor reset follows",
          ev_t[E_PR], ev_t[E_SS] + 1);
      chk(ev_t[E_DONE] == ev_t[E_PR], "R6 done with processor reset",
          ev_t[E_DONE], ev_t[E_PR]);
    end else begin
      chk(seq_err && !seq_done, "R7 timeout error", {seq_err, seq_done}, 2'b10);
      chk(io_clamp && wl_clamp && mem_clamp, "R7 clamps kept",
          {io_clamp, wl_clamp, mem_clamp}, 3'b111);
      chk(!subsys_rst && !proc_rst && ev_t[E_SS] < 0, "R7 resets unchanged",
          {subsys_rst, proc_rst}, 0);
      chk(ev_ms[E_ERR] - ev_ms[E_HS] >= PM, "R7 poll count before error",
          ev_ms[E_ERR] - ev_ms[E_HS], PM);
      repeat (20) @(negedge clk);
      chk(seq_err && !subsys_rst, "R7 error is sticky", int'(seq_err), 1);
    end
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed_71a3);
    for (int e = 0; e < NE; e++) ev_t[e] = -1;
    run_one(0, 1'b0);
    run_one(3, 1'b0);
    run_one(0, 1'b1);
    for (int n = 0; n < 4; n++) run_one(int'($urandom_range(PM - 2, 0)), 1'b0);
    run_one(PM - 1, 1'b0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule